// File: doc/BRIEF.md
# Boot-Block Sector Protection Manager

This block guards a 19-block flash array whose block sizes are uneven. It maps the upper bits of a word address onto a block number. The boot block sits either at the top or at the bottom of the space, chosen by a parameter. The block holds one protection flag per block. Each program or erase request gets a one-cycle grant or deny answer, so a request aimed at a protected block is simply dropped.

The protection flags are changed only through slow operations that need a high-voltage level flag. Protecting a single block takes a 100 µs wait. Clearing every flag takes a 10 ms wait, and is accepted only when all nineteen flags are already set. Both waits are counted in clock cycles derived from a clock-frequency parameter, and a busy output is high while one runs. A separate level flag, taken from the reset pin, lifts protection for as long as it is held. It never touches the stored flags, so protection returns the moment the flag drops. A verify request reads one block's flag back as a status byte.

Top module: `bootblk_prot_mgr`

## Requirements
- R1: With TOP_BOOT=1 the block select bits S = word-address bits 18..12 decode as follows. S[6:3] values 0 to 14 are fourteen-plus-one 32K-word blocks. The 16K-word block spans word addresses 0x78000 to 0x7BFFF. The two 4K-word blocks start at 0x7C000 and 0x7D000. The 8K-word boot block spans 0x7E000 to 0x7FFFF. Codes inside one block share its protection flag, and codes in different blocks never do.
- R2: With TOP_BOOT=0 the layout is mirrored from zero. The boot block spans 0x00000 to 0x01FFF, the 4K-word blocks start at 0x02000 and 0x03000, and the 16K-word block spans 0x04000 to 0x07FFF. Every S[6:3] value from 1 to 15 is its own 32K-word block.
- R3: After reset every protection flag is clear, grant, deny and busy are low, and status is 00h.
- R4: A request is accepted when req_valid is high and busy is low. Kind 0 is program and kind 1 is erase. One cycle after an accepted program or erase, exactly one of grant or deny pulses for one cycle. Grant pulses if the target block is unprotected or hv_unlock is high. Otherwise deny pulses. Kinds 5 to 7 have no effect.
- R5: hv_unlock does not change the stored flags. After it falls, blocks protected before it rose are denied again and still verify as protected.
- R6: A verify (kind 4) sets status one cycle later to 01h if the target block is protected and 00h if it is not. Status holds its value until the next accepted verify.
- R7: A protect (kind 2) with hv_prog high holds busy high for CLK_KHZ*PROTECT_US/1000 cycles and then sets the target block's flag. A protect with hv_prog low has no effect.
- R8: An unprotect (kind 3) is accepted only when hv_prog is high and all 19 flags are set. It holds busy high for CLK_KHZ*UNPROTECT_US/1000 cycles and then clears every flag. Otherwise it has no effect.
- R9: Any request made while busy is high is ignored: it gives no grant or deny, and it changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_sel | input | 7 | Word-address bits 18..12 of the target |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | 0 program, 1 erase, 2 protect, 3 unprotect all, 4 verify |
| hv_unlock | input | 1 | Temporary global unprotect level flag |
| hv_prog | input | 1 | High-voltage flag needed for protect and unprotect |
| grant | output | 1 | One-cycle pulse: program or erase allowed |
| deny | output | 1 | One-cycle pulse: program or erase dropped |
| busy | output | 1 | Protect or unprotect wait in progress |
| status | output | 8 | Verify result, 01h protected, 00h unprotected |

## Verification
The bench drives a top-boot and a bottom-boot instance together. It protects all 128 select codes one by one and re-reads every code after each step. This exposes a decode that merges the 4K-word pair, shifts the 32K-word blocks by one, or fails to mirror the small blocks. It tries an unprotect while only part of the array is protected, which a design that ignored the all-set rule would start. It also tries requests during a busy wait, which a design without the lockout would grant or record. The bench toggles the unlock flag and checks that denies come back afterwards, which fails if the flag were written into the stored bits. It counts busy cycles exactly, so an off-by-one in either wait shows up.

// File: rtl/bbpm_pkg.sv
package bbpm_pkg;
  localparam int NUM_BLOCKS = 19;
  localparam int BLK_W      = 5;
  localparam int SEL_W      = 7;

  typedef enum logic [2:0] {
    K_PROGRAM   = 3'd0,
    K_ERASE     = 3'd1,
    K_PROTECT   = 3'd2,
    K_UNPROTECT = 3'd3,
    K_VERIFY    = 3'd4
  } req_kind_e;

  // Block number in address order, 0 at the lowest address.
  function automatic logic [BLK_W-1:0] block_of(input logic [SEL_W-1:0] sel,
                                                input logic top_boot);
    logic [3:0] big;
    big = sel[6:3];
    if (top_boot) begin
      if (big != 4'hF) return {1'b0, big};
      if (!sel[2])     return 5'd15;
      if (!sel[1])     return sel[0] ? 5'd17 : 5'd16;
      return 5'd18;
    end else begin
      if (big != 4'h0) return 5'd3 + {1'b0, big};
      if (sel[2])      return 5'd3;
      if (!sel[1])     return 5'd0;
      return sel[0] ? 5'd2 : 5'd1;
    end
  endfunction

  function automatic int unsigned delay_cycles(input int unsigned khz,
                                               input int unsigned us);
    int unsigned r;
    r = (khz * us) / 1000;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/bbpm_decode.sv
module bbpm_decode
  import bbpm_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [BLK_W-1:0] idx
);
  always_comb idx = block_of(sel, TOP_BOOT);
endmodule

// File: rtl/bbpm_timer.sv
module bbpm_timer #(
  parameter int unsigned SHORT_CYC = 10,
  parameter int unsigned LONG_CYC  = 1000,
  localparam int CNT_W = $clog2(LONG_CYC) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= long_sel ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/bbpm_store.sv
module bbpm_store
  import bbpm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [BLK_W-1:0]      set_idx,
  input  logic                  clr_all,
  input  logic [BLK_W-1:0]      rd_idx,
  output logic                  rd_bit,
  output logic                  all_set,
  output logic [NUM_BLOCKS-1:0] bits
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bits[i] <= 1'b0;
      else if (clr_all)                             bits[i] <= 1'b0;
      else if (set_en && (set_idx == BLK_W'(i)))    bits[i] <= 1'b1;
    end
  end

  assign rd_bit  = bits[rd_idx];
  assign all_set = &bits;
endmodule

// File: rtl/bootblk_prot_mgr.sv
module bootblk_prot_mgr
  import bbpm_pkg::*;
#(
  parameter bit          TOP_BOOT     = 1'b1,
  parameter int unsigned CLK_KHZ      = 100000,
  parameter int unsigned PROTECT_US   = 100,
  parameter int unsigned UNPROTECT_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] blk_sel,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic             hv_unlock,
  input  logic             hv_prog,
  output logic             grant,
  output logic             deny,
  output logic             busy,
  output logic [7:0]       status
);
  localparam int unsigned PROT_CYC   = delay_cycles(CLK_KHZ, PROTECT_US);
  localparam int unsigned UNPROT_CYC = delay_cycles(CLK_KHZ, UNPROTECT_US);

  logic [BLK_W-1:0]      tgt_idx;
  logic [BLK_W-1:0]      op_idx_q;
  logic                  op_unprot_q;
  logic                  tgt_prot;
  logic                  all_set;
  logic [NUM_BLOCKS-1:0] prot_bits;
  logic                  accept, pe_req, allow, ver_req;
  logic                  prot_start, unprot_start, op_done;
  req_kind_e             kind;

  bbpm_decode #(.TOP_BOOT(TOP_BOOT)) u_dec (.sel(blk_sel), .idx(tgt_idx));

  always_comb begin
    kind         = req_kind_e'(req_kind);
    accept       = req_valid && !busy;
    pe_req       = accept && (kind == K_PROGRAM || kind == K_ERASE);
    ver_req      = accept && (kind == K_VERIFY);
    allow        = !tgt_prot || hv_unlock;
    prot_start   = accept && (kind == K_PROTECT) && hv_prog;
    unprot_start = accept && (kind == K_UNPROTECT) && hv_prog && all_set;
  end

  bbpm_timer #(.SHORT_CYC(PROT_CYC), .LONG_CYC(UNPROT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(prot_start || unprot_start), .long_sel(unprot_start),
    .busy(busy), .done(op_done)
  );

  bbpm_store u_store (
    .clk(clk), .rst_n(rst_n),
    .set_en(op_done && !op_unprot_q), .set_idx(op_idx_q),
    .clr_all(op_done && op_unprot_q),
    .rd_idx(tgt_idx), .rd_bit(tgt_prot), .all_set(all_set), .bits(prot_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant       <= 1'b0;
      deny        <= 1'b0;
      status      <= 8'h00;
      op_idx_q    <= '0;
      op_unprot_q <= 1'b0;
    end else begin
      grant <= pe_req && allow;
      deny  <= pe_req && !allow;
      if (ver_req) status <= {7'b0, tgt_prot};
      if (prot_start || unprot_start) begin
        op_idx_q    <= tgt_idx;
        op_unprot_q <= unprot_start;
      end
    end
  end
endmodule

// File: rtl/bbpm_checker.sv
module bbpm_checker #(
  parameter int NB = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_kind,
  input logic          hv_unlock,
  input logic          busy,
  input logic          grant,
  input logic          deny,
  input logic [7:0]    status,
  input logic          tgt_prot,
  input logic          op_unprot_q,
  input logic [NB-1:0] prot_bits
);
  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !deny); // R4
  AST_ANSWER_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> $past(req_valid && !busy)); // R9
  AST_DENY_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> ($past(tgt_prot) && !$past(hv_unlock))); // R4
  AST_UNLOCK_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && !busy && req_kind <= 3'd1) && $past(hv_unlock)) |-> grant); // R5
  AST_FLAGS_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_bits != $past(prot_bits)) |-> ($past(busy) && !busy)); // R7
  AST_UNPROT_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(op_unprot_q)) |-> (prot_bits == '0)); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && !busy && req_kind == 3'd4) |-> $stable(status)); // R6
endmodule

bind bootblk_prot_mgr bbpm_checker #(.NB(bbpm_pkg::NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .hv_unlock(hv_unlock), .busy(busy), .grant(grant), .deny(deny),
  .status(status), .tgt_prot(tgt_prot), .op_unprot_q(op_unprot_q),
  .prot_bits(prot_bits)
);

// File: tb/sim_bootblk_prot_mgr.sv
module sim_bootblk_prot_mgr;
  localparam int KHZ    = 100;
  localparam int P_CYC  = KHZ * 100 / 1000;
  localparam int U_CYC  = KHZ * 10000 / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] blk_sel = '0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic hv_unlock = 1'b0;
  logic hv_prog = 1'b0;
  logic g0, d0, b0, g1, d1, b1;
  logic [7:0] s0, s1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit expT [19];
  bit expB [19];

  always #5 clk = ~clk;

  bootblk_prot_mgr #(.TOP_BOOT(1'b1), .CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .req_valid(req_valid),
    .req_kind(req_kind), .hv_unlock(hv_unlock), .hv_prog(hv_prog),
    .grant(g0), .deny(d0), .busy(b0), .status(s0));
  bootblk_prot_mgr #(.TOP_BOOT(1'b0), .CLK_KHZ(KHZ)) u1 (
    .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .req_valid(req_valid),
    .req_kind(req_kind), .hv_unlock(hv_unlock), .hv_prog(hv_prog),
    .grant(g1), .deny(d1), .busy(b1), .status(s1));

  function automatic int blk_top(input int s);
    int a = s * 4096;
    if (a < 'h78000) return a / 'h8000;
    if (a < 'h7C000) return 15;
    if (a < 'h7D000) return 16;
    if (a < 'h7E000) return 17;
    return 18;
  endfunction

  function automatic int blk_bot(input int s);
    int a = s * 4096;
    if (a < 'h2000) return 0;
    if (a < 'h3000) return 1;
    if (a < 'h4000) return 2;
    if (a < 'h8000) return 3;
    return 3 + a / 'h8000;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic issue(input int kind, input int s);
    @(negedge clk);
    blk_sel = 7'(s); req_kind = 3'(kind); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic verify_all(input string rq);
    for (int s = 0; s < 128; s++) begin
      issue(4, s);
      chk({rq, " top status"}, s0, int'(expT[blk_top(s)]));
      chk({rq, " bottom status"}, s1, int'(expB[blk_bot(s)]));
    end
  endtask

  task automatic protect_code(input int s);
    int n = 0;
    issue(2, s);
    while (b0) begin n++; @(negedge clk); end
    chk("R7 protect busy cycles", n, P_CYC);
    chk("R7 bottom idle after protect", b1, 0);
    expT[blk_top(s)] = 1'b1;
    expB[blk_bot(s)] = 1'b1;
  endtask

  task automatic pe_sweep(input string rq, input bit unl);
    for (int s = 0; s < 128; s++) begin
      issue(s % 2, s);
      chk({rq, " top grant"}, g0, int'(unl || !expT[blk_top(s)]));
      chk({rq, " top deny"},  d0, int'(!unl && expT[blk_top(s)]));
      chk({rq, " bottom grant"}, g1, int'(unl || !expB[blk_bot(s)]));
      chk({rq, " bottom deny"},  d1, int'(!unl && expB[blk_bot(s)]));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 19; i++) begin expT[i] = 0; expB[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 grant", g0 | g1, 0);
    chk("R3 deny", d0 | d1, 0);
    chk("R3 busy", b0 | b1, 0);
    chk("R3 status", s0 | s1, 0);
    verify_all("R3 flags clear");

    // R8 unprotect with nothing protected is ignored
    hv_prog = 1'b1;
    issue(3, 0);
    chk("R8 unprotect ignored, none set", b0 | b1, 0);

    // R7 protect without the high-voltage flag is ignored
    hv_prog = 1'b0;
    issue(2, 5);
    chk("R7 no hv_prog busy", b0 | b1, 0);
    issue(4, 5);
    chk("R7 no hv_prog flag", s0 | s1, 0);

    // R4 reserved kind has no effect
    hv_prog = 1'b1;
    issue(6, 9);
    chk("R4 reserved kind", int'({g0, d0, b0, g1, d1, b1}), 0);

    // R9 requests while busy are ignored
    issue(2, 3);
    expT[blk_top(3)] = 1'b1; expB[blk_bot(3)] = 1'b1;
    issue(0, 0);
    chk("R9 no answer while busy", int'({g0, d0, g1, d1}), 0);
    issue(2, 100);
    while (b0 || b1) @(negedge clk);
    verify_all("R9 busy protect dropped");

    // R1 R2 decode sweep, first half
    for (int s = 0; s < 64; s++) begin
      protect_code(s);
      verify_all("R1 R2 decode");
    end

    // R8 unprotect while only part is protected
    issue(3, 0);
    chk("R8 partial set ignored", b0 | b1, 0);
    verify_all("R8 flags kept");

    // R4 then R5
    hv_unlock = 1'b0;
    pe_sweep("R4 locked", 1'b0);
    issue(0, 127);
    @(negedge clk);
    chk("R4 pulse width", int'({g0, d0, g1, d1}), 0);
    hv_unlock = 1'b1;
    pe_sweep("R5 unlocked", 1'b1);
    hv_unlock = 1'b0;
    pe_sweep("R5 relocked", 1'b0);
    verify_all("R5 flags unchanged");

    // R1 R2 second half
    for (int s = 64; s < 128; s++) begin
      protect_code(s);
      verify_all("R1 R2 decode");
    end

    // R8 no hv_prog
    hv_prog = 1'b0;
    issue(3, 0);
    chk("R8 no hv_prog", b0 | b1, 0);

    // R8 full unprotect
    hv_prog = 1'b1;
    issue(3, 0);
    n = 0;
    while (b0) begin n++; @(negedge clk); end
    chk("R8 unprotect busy cycles", n, U_CYC);
    chk("R8 bottom done together", b1, 0);
    for (int i = 0; i < 19; i++) begin expT[i] = 0; expB[i] = 0; end
    verify_all("R8 all cleared");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule